// File: doc/BRIEF.md
# BCD Decade Counter with Preset and Cascade Output

This block is a four-bit synchronous counter that steps through the decimal digits 0 to 9 in 8421 binary-coded-decimal form. After 9 it returns to 0. It serves as one digit of a decimal counter or as a programmable divide-by-N stage. A four-bit preset value can be loaded on a clock edge. Two count enables gate the increment. A terminal-count output lets several digits be chained into one synchronous multi-digit counter.

The two count enables play different roles. The parallel enable only gates counting. The trickle enable gates counting and also gates the terminal-count output. An elaboration parameter picks the reset style. One style clears the digit asynchronously as soon as the reset input goes low. The other clears it on the next rising clock edge.

The six codes 10 to 15 are not part of the decimal sequence. Counting from any of them leads back into the 0 to 9 sequence within two count steps.

Top module: `bcd_decade_counter`

## Requirements
- R1: With reset inactive, load_n high and both count enables high, each rising edge moves q from n to n+1 for n in 0..8, and from 9 to 0.
- R2: With RESET_ASYNC=0, rst_n low at a rising edge makes q equal 0 after that edge, whatever load_n, the count enables and preset are. Before that edge q keeps its value.
- R3: With RESET_ASYNC=1, rst_n going low clears q to 0 at once, with no clock edge, and q stays 0 while rst_n is low.
- R4: With reset inactive, load_n low at a rising edge puts preset into q, for every preset value 0..15 and whatever the count enables are.
- R5: With reset inactive and load_n high, q keeps its value across a rising edge when cnt_en_p is low or cnt_en_t is low.
- R6: tc is 1 exactly when q equals 9 (binary 1001) and cnt_en_t is 1. It is combinational and does not depend on cnt_en_p.
- R7: tc is 0 whenever q holds one of the codes 10..15, whatever cnt_en_t is.
- R8: A count step from a code outside the decimal range follows the mapping 10→11, 11→6, 12→13, 13→4, 14→15, 15→2. Every illegal code therefore reaches 0..9 within at most two count steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset; asynchronous or synchronous according to RESET_ASYNC |
| load_n | input | 1 | Active-low parallel load of preset |
| cnt_en_p | input | 1 | Count enable that gates counting only |
| cnt_en_t | input | 1 | Count enable that gates counting and tc |
| preset | input | 4 | Value loaded when load_n is low |
| q | output | 4 | Current BCD digit |
| tc | output | 1 | Terminal count: q is 9 while cnt_en_t is high |

## Verification
The bench loads every one of the sixteen codes as a start state. From each start state it applies all eight combinations of load_n and the two count enables. This shows apart load precedence, counting, and a hold caused by each enable on its own. It also shows the legal successor from the illegal-code successor, and how tc reacts to each enable. A long free-running count shows the 9-to-0 wrap. Reset is driven both between edges and at edges, with load and count requests active. This shows the immediate clear of the asynchronous build apart from the edge-timed clear of the synchronous build.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
   localparam int DIGIT_W   = 4;
   localparam int LAST_CODE = 9;

   typedef logic [DIGIT_W-1:0] digit_t;

   typedef enum logic [1:0] {
      OP_HOLD  = 2'd0,
      OP_COUNT = 2'd1,
      OP_LOAD  = 2'd2
   } op_t;

   // successor of a code under one count step, including the six
   // out-of-range codes which are steered back into the decimal cycle
   function automatic digit_t bcd_succ(input digit_t cur);
      digit_t nxt;
      case (cur)
         4'd10:   nxt = 4'd11;
         4'd11:   nxt = 4'd6;
         4'd12:   nxt = 4'd13;
         4'd13:   nxt = 4'd4;
         4'd14:   nxt = 4'd15;
         4'd15:   nxt = 4'd2;
         default: nxt = (cur == digit_t'(LAST_CODE)) ? '0 : cur + digit_t'(1);
      endcase
      return nxt;
   endfunction
endpackage

// File: rtl/bcd_next_state.sv
module bcd_next_state
   import bcd_pkg::*;
(
   input  digit_t cur,
   input  logic   load_n,
   input  logic   cnt_en_p,
   input  logic   cnt_en_t,
   input  digit_t preset,
   output digit_t nxt
);
   op_t op;

   always_comb begin
      if (!load_n)                  op = OP_LOAD;
      else if (cnt_en_p && cnt_en_t) op = OP_COUNT;
      else                          op = OP_HOLD;
   end

   always_comb begin
      unique case (op)
         OP_LOAD:  nxt = preset;
         OP_COUNT: nxt = bcd_succ(cur);
         default:  nxt = cur;
      endcase
   end
endmodule

// File: rtl/bcd_state_reg.sv
module bcd_state_reg
   import bcd_pkg::*;
#(
   parameter bit RESET_ASYNC = 1'b1
)(
   input  logic   clk,
   input  logic   rst_n,
   input  digit_t d,
   output digit_t q
);
   generate
      if (RESET_ASYNC) begin : g_async
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= d;
         end
      end else begin : g_sync
         always_ff @(posedge clk) begin
            if (!rst_n) q <= '0;
            else        q <= d;
         end
      end
   endgenerate
endmodule

// File: rtl/bcd_tc_decode.sv
module bcd_tc_decode
   import bcd_pkg::*;
(
   input  digit_t cur,
   input  logic   cnt_en_t,
   output logic   tc
);
   // full decode: every bit compared, so codes 11, 13, 15 never match
   assign tc = cnt_en_t && (cur == digit_t'(LAST_CODE));
endmodule

// File: rtl/bcd_decade_counter.sv
module bcd_decade_counter
   import bcd_pkg::*;
#(
   parameter bit RESET_ASYNC = 1'b1
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_n,
   input  logic               cnt_en_p,
   input  logic               cnt_en_t,
   input  logic [DIGIT_W-1:0] preset,
   output logic [DIGIT_W-1:0] q,
   output logic               tc
);
   initial begin
      assert (DIGIT_W == 4 && LAST_CODE == 9)
         else $error("bcd_decade_counter: digit must be 4-bit decimal");
   end

   digit_t d_next;

   bcd_next_state u_next (
      .cur      (q),
      .load_n   (load_n),
      .cnt_en_p (cnt_en_p),
      .cnt_en_t (cnt_en_t),
      .preset   (preset),
      .nxt      (d_next)
   );

   bcd_state_reg #(.RESET_ASYNC(RESET_ASYNC)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (d_next),
      .q     (q)
   );

   bcd_tc_decode u_tc (
      .cur      (q),
      .cnt_en_t (cnt_en_t),
      .tc       (tc)
   );
endmodule

// File: rtl/bcd_decade_counter_chk.sv
module bcd_decade_counter_chk #(
   parameter bit RESET_ASYNC = 1'b1
)(
   input logic       clk,
   input logic       rst_n,
   input logic       load_n,
   input logic       cnt_en_p,
   input logic       cnt_en_t,
   input logic [3:0] preset,
   input logic [3:0] q,
   input logic       tc
);
   logic do_cnt;
   assign do_cnt = load_n && cnt_en_p && cnt_en_t;

   AST_WRAP_NINE: assert property (@(posedge clk) disable iff (!rst_n)
      (do_cnt && q == 4'd9) |=> (q == 4'd0)); // R1
   AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (do_cnt && q < 4'd9) |=> (q == $past(q) + 4'd1)); // R1
   AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_n) |=> (q == $past(preset))); // R4
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (load_n && !(cnt_en_p && cnt_en_t)) |=> $stable(q)); // R5
   AST_TC_AT_NINE: assert property (@(posedge clk)
      tc |-> (q == 4'd9 && cnt_en_t)); // R6
   AST_TC_ILLEGAL_LOW: assert property (@(posedge clk)
      (q > 4'd9) |-> !tc); // R7
   AST_ILLEGAL_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
      (do_cnt && q > 4'd9 && !q[0]) |=> (q == $past(q) + 4'd1)); // R8
   AST_ILLEGAL_ODD: assert property (@(posedge clk) disable iff (!rst_n)
      (do_cnt && q > 4'd9 && q[0]) |=> (q <= 4'd9)); // R8

   generate
      if (RESET_ASYNC) begin : g_async_chk
         AST_ASYNC_CLEAR: assert property (@(posedge clk)
            (!rst_n) |-> (q == 4'd0)); // R3
      end else begin : g_sync_chk
         AST_SYNC_CLEAR: assert property (@(posedge clk)
            (!rst_n) |=> (q == 4'd0)); // R2
      end
   endgenerate
endmodule

bind bcd_decade_counter bcd_decade_counter_chk #(.RESET_ASYNC(RESET_ASYNC)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .load_n   (load_n),
   .cnt_en_p (cnt_en_p),
   .cnt_en_t (cnt_en_t),
   .preset   (preset),
   .q        (q),
   .tc       (tc)
);

// File: tb/bcd_decade_counter_tb.sv
module bcd_decade_counter_tb;
   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       load_n = 1'b1;
   logic       cnt_en_p = 1'b0;
   logic       cnt_en_t = 1'b0;
   logic [3:0] preset = 4'd0;
   logic [3:0] q_a, q_s;
   logic       tc_a, tc_s;

   int n_run = 0;
   int n_fail = 0;
   logic [3:0] exp_a = 4'd0;
   logic [3:0] exp_s = 4'd0;

   always #(CLK_P/2) clk = ~clk;

   bcd_decade_counter #(.RESET_ASYNC(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .load_n(load_n), .cnt_en_p(cnt_en_p),
      .cnt_en_t(cnt_en_t), .preset(preset), .q(q_a), .tc(tc_a));

   bcd_decade_counter #(.RESET_ASYNC(1'b0)) u_dut_sync (
      .clk(clk), .rst_n(rst_n), .load_n(load_n), .cnt_en_p(cnt_en_p),
      .cnt_en_t(cnt_en_t), .preset(preset), .q(q_s), .tc(tc_s));

   // independent successor: even illegal codes step up, odd ones fold to 17-code
   function automatic logic [3:0] succ(input logic [3:0] c);
      int v = int'(c);
      if (v < 9)           return 4'(v + 1);
      else if (v == 9)     return 4'd0;
      else if (v % 2 == 0) return 4'(v + 1);
      else                 return 4'(17 - v);
   endfunction

   function automatic logic [3:0] model(input logic [3:0] c, input logic r,
      input logic ld, input logic p, input logic t, input logic [3:0] pv);
      if (!r)         return 4'd0;
      else if (!ld)   return pv;
      else if (p && t) return succ(c);
      else            return c;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // set inputs, check tc combinationally, clock once, check q on both builds
   task automatic apply(input string req, input logic r, input logic ld,
      input logic p, input logic t, input logic [3:0] pv);
      rst_n = r; load_n = ld; cnt_en_p = p; cnt_en_t = t; preset = pv;
      #1;
      if (r) begin
         check((exp_a > 9) ? "R7 tc async" : "R6 tc async", int'(tc_a),
               int'(exp_a == 4'd9 && t));
         check((exp_s > 9) ? "R7 tc sync" : "R6 tc sync", int'(tc_s),
               int'(exp_s == 4'd9 && t));
      end
      @(posedge clk);
      #1;
      exp_a = model(exp_a, r, ld, p, t, pv);
      exp_s = model(exp_s, r, ld, p, t, pv);
      check({req, " async"}, int'(q_a), int'(exp_a));
      check({req, " sync"}, int'(q_s), int'(exp_s));
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : main
      repeat (2) @(posedge clk);
      #1;
      check("R3 reset state async", int'(q_a), 0);
      check("R2 reset state sync", int'(q_s), 0);
      check("R6 tc in reset", int'(tc_a | tc_s), 0);

      // long free run: wrap 9 -> 0 (R1)
      for (int i = 0; i < 25; i++) apply("R1 count", 1'b1, 1'b1, 1'b1, 1'b1, 4'd0);

      // every start code x every control combination
      for (int s = 0; s < 16; s++) begin
         for (int c = 0; c < 8; c++) begin
            logic ld, p, t;
            ld = c[2]; p = c[1]; t = c[0];
            apply("R4 preload", 1'b1, 1'b0, c[0], c[1], 4'(s));
            if (!ld)          apply("R4 load", 1'b1, ld, p, t, 4'(s + 7));
            else if (p && t)  apply((s > 9) ? "R8 illegal step" : "R1 count", 1'b1, ld, p, t, 4'(s + 7));
            else              apply("R5 hold", 1'b1, ld, p, t, 4'(s + 7));
         end
      end

      // recovery from every illegal code within two counts (R8)
      for (int s = 10; s < 16; s++) begin
         apply("R4 preload", 1'b1, 1'b0, 1'b0, 1'b0, 4'(s));
         apply("R8 step one", 1'b1, 1'b1, 1'b1, 1'b1, 4'd0);
         apply("R8 step two", 1'b1, 1'b1, 1'b1, 1'b1, 4'd0);
         check("R8 legal after two", int'(q_a <= 4'd9), 1);
      end

      // tc ignores cnt_en_p at 9 (R6)
      apply("R4 preload", 1'b1, 1'b0, 1'b1, 1'b1, 4'd9);
      rst_n = 1'b1; load_n = 1'b1; cnt_en_p = 1'b0; cnt_en_t = 1'b1;
      #1;
      check("R6 tc with p low", int'(tc_a), 1);
      cnt_en_t = 1'b0;
      #1;
      check("R6 tc with t low", int'(tc_a), 0);

      // reset between edges: async clears at once, sync waits for edge
      apply("R4 preload", 1'b1, 1'b0, 1'b1, 1'b1, 4'd6);
      @(negedge clk);
      rst_n = 1'b0; load_n = 1'b0; cnt_en_p = 1'b1; cnt_en_t = 1'b1; preset = 4'd5;
      #1;
      check("R3 async clear without edge", int'(q_a), 0);
      check("R2 sync waits for edge", int'(q_s), 6);
      @(posedge clk);
      #1;
      check("R2 sync clear over load", int'(q_s), 0);
      check("R3 async stays clear", int'(q_a), 0);
      exp_a = 4'd0; exp_s = 4'd0;
      apply("R2 reset over count", 1'b0, 1'b1, 1'b1, 1'b1, 4'd3);
      apply("R1 count after reset", 1'b1, 1'b1, 1'b1, 1'b1, 4'd3);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule